// File: doc/BRIEF.md
# Banked GPIO Register File with Per-Pin Drive Mode

This block is the general-purpose pin function that sits behind a byte-wide configuration window. It holds several banks of pins, with up to eight pins in each bank. Every bank decodes four adjacent byte registers:

- a direction register;
- an output latch;
- a read-only view of the pin levels;
- a drive-mode register that makes each output either push-pull or open-drain.

The block drives an output-enable and an output-value line for each pad. It brings every pad's input level in through a two-stage synchronizer.

The configuration controller presents an 8-bit address, a write strobe and write data. Read data returns combinationally for the address currently presented. Writes take effect at the next rising clock edge. The number of pins in each bank is a parameter. Bits for pins a bank does not implement read as zero and never drive a pad.

Top module: `gpiob_top`

## Requirements
- R1: After reset every direction, output-latch and drive-mode bit is 0, so no pad is driven (`padOe` and `padOut` all 0) and those registers read 0.
- R2: Bank k (k = 0..7) has its base at 0xF0 − 0x10·k, and bank 8 has its base at 0x88. The low two address bits select the register: 0 = direction, 1 = output latch, 2 = pin level, 3 = drive mode. Pad bit p of bank k is index 8·k + p of the pad vectors.
- R3: A direction bit of 0 makes the pin an input with `padOe` low. A direction bit of 1 makes it an output.
- R4: For an output pin with drive-mode bit 1 (push-pull), `padOe` is 1 and `padOut` equals the latch bit.
- R5: For an output pin with drive-mode bit 0 (open-drain), `padOut` is 0 and `padOe` is 1 only while the latch bit is 0.
- R6: The pin-level register returns each pin's input as it was two rising edges earlier, whatever the pin's direction.
- R7: Writes to the pin-level register (offset 2) change no state.
- R8: In a bank with fewer than 8 pins, the unimplemented bits read 0, ignore writes, and keep their `padOe` and `padOut` at 0.
- R9: The output-latch register reads back the stored value, not the pin level.
- R10: Addresses that fall in no bank read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgAddr | input | 8 | Register address |
| cfgWrEn | input | 1 | Write strobe |
| cfgWrData | input | 8 | Write data |
| cfgRdData | output | 8 | Read data for `cfgAddr` (combinational) |
| padIn | input | NUM_BANKS*8 | Pad input levels |
| padOe | output | NUM_BANKS*8 | Pad output enables |
| padOut | output | NUM_BANKS*8 | Pad output values |

## Verification
The assertions check the following on every cycle:

- no pad drives high without its enable;
- unimplemented pins never drive;
- writes to the pin-level offset or to unmapped space leave the pads unchanged;
- unmapped reads return zero;
- the bank-0 pin-level register follows the inputs with exactly two cycles of delay.

Only the bench scenarios can show the per-bank address decode, the masking of write data to each bank's width, the switch between push-pull and open-drain drive, and the output latch reading back its stored value rather than the pin.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;

  localparam int GPB_MAX_BANKS = 9;
  localparam int GPB_SEL_W     = 4;

  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_OUT  = 2'd1,
    REG_STAT = 2'd2,
    REG_MODE = 2'd3
  } regSel_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic [GPB_MAX_BANKS-1:0] wrDir;
    logic [GPB_MAX_BANKS-1:0] wrOut;
    logic [GPB_MAX_BANKS-1:0] wrMode;
    logic                     hit;
    logic [GPB_SEL_W-1:0]     bankSel;
    regSel_e                  regSel;
  } ctrlStrobe_t;

  // Base address of bank idx. Banks 0..7 descend in 0x10 steps; bank 8 sits at 0x88.
  function automatic logic [7:0] bankBase(input int idx);
    if (idx == 8) return 8'h88;
    return 8'(240 - 16 * idx);
  endfunction

  // Mask of the implemented pins for a bank with the given pin count.
  function automatic logic [7:0] pinMask(input int pins);
    logic [8:0] full;
    full = (9'd1 << pins) - 9'd1;
    return full[7:0];
  endfunction

endpackage

// File: rtl/gpiob_ctrl.sv
module gpiob_ctrl
  import gpiob_pkg::*;
#(
  parameter int NUM_BANKS = 9
) (
  input  logic [7:0]  cfgAddr,
  input  logic        cfgWrEn,
  output ctrlStrobe_t strb
);

  always_comb begin
    strb        = '0;
    strb.regSel = regSel_e'(cfgAddr[1:0]);
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic [7:0] base;
      base = bankBase(b);
      if (cfgAddr[7:2] == base[7:2]) begin
        strb.hit     = 1'b1;
        strb.bankSel = GPB_SEL_W'(b);
        if (cfgWrEn) begin
          unique case (regSel_e'(cfgAddr[1:0]))
            REG_DIR:  strb.wrDir[b]  = 1'b1;
            REG_OUT:  strb.wrOut[b]  = 1'b1;
            REG_MODE: strb.wrMode[b] = 1'b1;
            REG_STAT: ; // read-only register: the write is dropped
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/gpiob_bank.sv
module gpiob_bank
  import gpiob_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrDir,
  input  logic       wrOut,
  input  logic       wrMode,
  input  logic [7:0] wrData,
  input  logic [7:0] padIn,
  output logic [7:0] padOe,
  output logic [7:0] padOut,
  output logic [7:0] dirRd,
  output logic [7:0] outRd,
  output logic [7:0] modeRd,
  output logic [7:0] statRd
);

  localparam logic [7:0] MASK = pinMask(PINS);

  logic [7:0] dirQ, outQ, modeQ, sync1Q, sync2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      outQ   <= '0;
      modeQ  <= '0;
      sync1Q <= '0;
      sync2Q <= '0;
    end else begin
      if (wrDir)  dirQ  <= wrData & MASK;
      if (wrOut)  outQ  <= wrData & MASK;
      if (wrMode) modeQ <= wrData & MASK;
      sync1Q <= padIn & MASK;
      sync2Q <= sync1Q;
    end
  end

  // Open-drain pins drive only while low; push-pull pins always drive.
  assign padOe  = dirQ & (modeQ | ~outQ);
  assign padOut = padOe & modeQ & outQ;

  assign dirRd  = dirQ;
  assign outRd  = outQ;
  assign modeRd = modeQ;
  assign statRd = sync2Q;

endmodule

// File: rtl/gpiob_datapath.sv
module gpiob_datapath
  import gpiob_pkg::*;
#(
  parameter int                     NUM_BANKS = 9,
  parameter logic [NUM_BANKS*4-1:0] BANK_PINS = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [7:0]             wrData,
  input  logic [NUM_BANKS*8-1:0] padIn,
  output logic [NUM_BANKS*8-1:0] padOe,
  output logic [NUM_BANKS*8-1:0] padOut,
  output logic [7:0]             rdData
);

  localparam int VEC_W = NUM_BANKS * 8;

  logic [VEC_W-1:0] dirAll, outAll, modeAll, statAll;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpiob_bank #(
      .PINS(int'(BANK_PINS[b*4 +: 4]))
    ) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .wrDir  (strb.wrDir[b]),
      .wrOut  (strb.wrOut[b]),
      .wrMode (strb.wrMode[b]),
      .wrData (wrData),
      .padIn  (padIn[b*8 +: 8]),
      .padOe  (padOe[b*8 +: 8]),
      .padOut (padOut[b*8 +: 8]),
      .dirRd  (dirAll[b*8 +: 8]),
      .outRd  (outAll[b*8 +: 8]),
      .modeRd (modeAll[b*8 +: 8]),
      .statRd (statAll[b*8 +: 8])
    );
  end

  always_comb begin
    rdData = '0;
    if (strb.hit) begin
      unique case (strb.regSel)
        REG_DIR:  rdData = dirAll[int'(strb.bankSel)*8 +: 8];
        REG_OUT:  rdData = outAll[int'(strb.bankSel)*8 +: 8];
        REG_STAT: rdData = statAll[int'(strb.bankSel)*8 +: 8];
        REG_MODE: rdData = modeAll[int'(strb.bankSel)*8 +: 8];
      endcase
    end
  end

endmodule

// File: rtl/gpiob_top.sv
module gpiob_top
  import gpiob_pkg::*;
#(
  parameter int                     NUM_BANKS = 9,
  parameter logic [NUM_BANKS*4-1:0] BANK_PINS = {4'd8, 4'd8, 4'd8, 4'd7, 4'd5, 4'd4, 4'd8, 4'd8, 4'd6}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             cfgAddr,
  input  logic                   cfgWrEn,
  input  logic [7:0]             cfgWrData,
  output logic [7:0]             cfgRdData,
  input  logic [NUM_BANKS*8-1:0] padIn,
  output logic [NUM_BANKS*8-1:0] padOe,
  output logic [NUM_BANKS*8-1:0] padOut
);

  ctrlStrobe_t strb;

  gpiob_ctrl #(
    .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .cfgAddr (cfgAddr),
    .cfgWrEn (cfgWrEn),
    .strb    (strb)
  );

  gpiob_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_PINS(BANK_PINS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (cfgWrData),
    .padIn  (padIn),
    .padOe  (padOe),
    .padOut (padOut),
    .rdData (cfgRdData)
  );

endmodule

// File: rtl/gpiob_checker.sv
module gpiob_checker
  import gpiob_pkg::*;
#(
  parameter int                     NUM_BANKS = 9,
  parameter logic [NUM_BANKS*4-1:0] BANK_PINS = '0
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [7:0]             cfgAddr,
  input logic                   cfgWrEn,
  input logic [7:0]             cfgRdData,
  input logic [NUM_BANKS*8-1:0] padIn,
  input logic [NUM_BANKS*8-1:0] padOe,
  input logic [NUM_BANKS*8-1:0] padOut
);

  function automatic logic [NUM_BANKS*8-1:0] implMask();
    logic [NUM_BANKS*8-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++) m[b*8 +: 8] = pinMask(int'(BANK_PINS[b*4 +: 4]));
    return m;
  endfunction

  localparam logic [NUM_BANKS*8-1:0] IMPL   = implMask();
  localparam logic [7:0]             STAT0  = bankBase(0) | 8'h02;

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0));

  // R4 and R5: a pad never presents a high value without its enable
  a_r4_out_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);

  a_r8_unimpl_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & ~IMPL) == '0);

  a_r7_stat_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr[1:0] == 2'd2) |=> ($stable(padOe) && $stable(padOut)));

  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rstN)
    !cfgAddr[7] |-> cfgRdData == 8'h00);

  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgAddr[7]) |=> ($stable(padOe) && $stable(padOut)));

  a_r6_stat_delay: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && cfgAddr == STAT0) |-> cfgRdData == ($past(padIn[7:0], 2) & IMPL[7:0]));

endmodule

bind gpiob_top gpiob_checker #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_PINS(BANK_PINS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgAddr   (cfgAddr),
  .cfgWrEn   (cfgWrEn),
  .cfgRdData (cfgRdData),
  .padIn     (padIn),
  .padOe     (padOe),
  .padOut    (padOut)
);

// File: tb/gpiob_top_bench.sv
`timescale 1ns/1ps
module gpiob_top_bench;

  localparam int NB = 9;
  localparam int W  = NB * 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   cfgAddr = '0;
  logic         cfgWrEn = 1'b0;
  logic [7:0]   cfgWrData = '0;
  logic [7:0]   cfgRdData;
  logic [W-1:0] padIn = '0;
  logic [W-1:0] padOe, padOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  gpiob_top u_gpiob_top (
    .clk       (clk),
    .rstN      (rstN),
    .cfgAddr   (cfgAddr),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] expd;
    logic [7:0] req;
  } vec_t;

  // Write data, then read the same address back.
  localparam vec_t VECS [10] = '{
    '{8'hF0, 8'hFF, 8'h3F, 8'd8},   // R8: bank 0 has 6 pins
    '{8'hE1, 8'hA5, 8'hA5, 8'd9},   // R9: latch readback
    '{8'hC3, 8'hFF, 8'h0F, 8'd8},   // R8: bank 3 has 4 pins
    '{8'hB0, 8'hFF, 8'h1F, 8'd8},   // R8: bank 4 has 5 pins
    '{8'hA1, 8'hFF, 8'h7F, 8'd8},   // R8: bank 5 has 7 pins
    '{8'h88, 8'h3C, 8'h3C, 8'd2},   // R2: odd ninth bank
    '{8'h80, 8'hC3, 8'hC3, 8'd2},   // R2: bank 7
    '{8'h12, 8'h55, 8'h00, 8'd10},  // R10: unmapped
    '{8'hD2, 8'hFF, 8'h00, 8'd7},   // R7: pin-level write dropped
    '{8'h93, 8'h81, 8'h81, 8'd2}    // R2: bank 6 drive mode
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired: actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(1, "padOe after reset", 32'(padOe != '0), 0);
    check(1, "padOut after reset", 32'(padOut != '0), 0);
    rd(8'hF0, r); check(1, "dir reset", 32'(r), 0);
    rd(8'hF1, r); check(1, "out reset", 32'(r), 0);
    rd(8'hB3, r); check(1, "mode reset", 32'(r), 0);

    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].addr, VECS[i].data);
      rd(VECS[i].addr, r);
      check(int'(VECS[i].req), $sformatf("vector %0d addr %h", i, VECS[i].addr), 32'(r), 32'(VECS[i].expd));
    end

    // R8: bank 0 push-pull with latch 0; pins 6 and 7 stay quiet
    wr(8'hF3, 8'hFF);
    wr(8'hF1, 8'h00);
    check(8, "bank0 padOe", 32'(padOe[7:0]), 32'h3F);
    check(8, "bank0 padOut", 32'(padOut[7:0]), 32'h00);

    // R4: bank 1 push-pull, latch A5
    wr(8'hE0, 8'hFF);
    wr(8'hE3, 8'hFF);
    check(4, "push-pull padOe", 32'(padOe[15:8]), 32'hFF);
    check(4, "push-pull padOut", 32'(padOut[15:8]), 32'hA5);

    // R9 and R6: latch readback ignores pins; pin level seen with outputs on
    padIn[15:8] = 8'h5A;
    repeat (3) @(negedge clk);
    rd(8'hE1, r); check(9, "latch vs pin", 32'(r), 32'hA5);
    rd(8'hE2, r); check(6, "pin level on output bank", 32'(r), 32'h5A);

    // R5: open-drain drives only the zero bits
    wr(8'hE3, 8'h00);
    check(5, "open-drain padOe", 32'(padOe[15:8]), 32'h5A);
    check(5, "open-drain padOut", 32'(padOut[15:8]), 32'h00);

    // R3: clearing direction bits releases pads
    wr(8'hE0, 8'h0F);
    check(3, "direction mask padOe", 32'(padOe[15:8]), 32'h0A);

    // R7: write to pin-level register leaves state alone
    wr(8'hE2, 8'hFF);
    rd(8'hE2, r); check(7, "pin level after write", 32'(r), 32'h5A);
    check(7, "padOe after pin-level write", 32'(padOe[15:8]), 32'h0A);
    rd(8'hE0, r); check(7, "dir after pin-level write", 32'(r), 32'h0F);

    // R6: two-edge synchronizer delay on bank 2
    @(negedge clk);
    padIn[23:16] = 8'h3C;
    rd(8'hD2, r); check(6, "sync delay 0", 32'(r), 32'h00);
    @(negedge clk);
    rd(8'hD2, r); check(6, "sync delay 1", 32'(r), 32'h00);
    @(negedge clk);
    rd(8'hD2, r); check(6, "sync delay 2", 32'(r), 32'h3C);

    // R10: gap after the ninth bank is unmapped
    wr(8'h8C, 8'hFF);
    rd(8'h8C, r); check(10, "gap read", 32'(r), 32'h00);
    rd(8'h88, r); check(10, "bank8 after gap write", 32'(r), 32'h3C);
    // R2: neighbouring banks stay distinct
    rd(8'h80, r); check(2, "bank7 dir", 32'(r), 32'hC3);
    rd(8'h91, r); check(2, "bank6 latch", 32'(r), 32'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule